// File: doc/BRIEF.md
# Indirect Message Bus Bridge

This block lets a host reach registers inside internal units without mapping them into its own address space. The host sees only two 32-bit configuration registers: a command word and a data word. Writing the command word names an operation, a destination port, a register offset and a byte mask. The bridge then runs one transaction on an internal request/response bus. A read result comes back through the data word. Write data must be placed in the data word before the command word is written.

The internal side has a request channel with a valid/ready handshake. It carries the port, offset, direction, byte mask and data. A separate response channel carries a valid strobe and read data. Only one transaction is ever in flight. A busy output covers the whole time from the command write until the response arrives. While busy, the bridge ignores host writes and keeps the data word at its previous contents.

Top module: `msgbus_bridge`

## Requirements
- R1: After reset, `busy` and `req_valid` are 0, and host reads at the command offset (0xD0) and at the data offset (0xD4) both return 0.
- R2: While idle, a host write at offset 0xD4 loads the data word. A host read returns the command word at 0xD0, the data word at 0xD4 and zero at any other offset, all combinationally.
- R3: A command write while idle stores all 32 bits. These bits read back unchanged at 0xD0. The fields are operation in bits [31:24], port in [23:16], register offset in [15:8], byte mask in [7:4] and unused bits in [3:0]. The request's port, offset and byte mask are taken from these fields.
- R4: Operation code 0xE0 issues a request with `req_write`=1. `req_data` equals the data word with every byte whose mask bit (bit b covers bits [8b+7:8b]) is 0 forced to zero.
- R5: Operation code 0xD0 issues a request with `req_write`=0. When the response arrives, the data word takes `rsp_data` with every byte whose mask bit is 0 forced to zero.
- R6: Any other operation code is still stored as the command word, but it issues no request and `busy` stays 0.
- R7: `busy` rises in the cycle after an accepted command write with a valid operation code, together with `req_valid`. It falls in the cycle after `rsp_valid` is seen with the request already accepted. While busy, the data offset returns the previous data word.
- R8: `req_valid` and all request fields hold steady until `req_ready` is seen. `rsp_valid` has no effect unless the request has been accepted and is still waiting for its response.
- R9: Host writes to either register while `busy` is 1 are ignored.
- R10: The response to a write operation leaves the data word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Host write strobe |
| cfg_addr | input | 8 | Host configuration offset |
| cfg_wdata | input | 32 | Host write data |
| cfg_rdata | output | 32 | Host read data (combinational) |
| busy | output | 1 | Transaction in progress |
| req_valid | output | 1 | Internal request valid |
| req_ready | input | 1 | Internal request accepted |
| req_port | output | 8 | Destination port |
| req_offset | output | 8 | Register offset at the destination |
| req_write | output | 1 | 1 for write, 0 for read |
| req_be | output | 4 | Byte mask |
| req_data | output | 32 | Masked write data |
| rsp_valid | input | 1 | Response strobe |
| rsp_data | input | 32 | Response read data |

## Verification
The bench builds the bridge with its default parameters: an 8-bit offset space, the command word at 0xD0 and the data word at 0xD4. Random host traffic therefore hits both registers and also nearby unused offsets. The responder stalls `req_ready` at random, varies response latency, and injects stray `rsp_valid` pulses while the bridge is idle or still issuing. This exercises the handshake hold, the rule that responses are ignored until the request is accepted, and host writes that land while busy. Partial byte masks on both reads and writes show the zeroing of disabled bytes against a behavioural register store.

// File: rtl/mbb_pkg.sv
package mbb_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_N = WORD_W / 8;
    localparam int PORT_W = 8;
    localparam int OFS_W  = 8;
    localparam int OP_W   = 8;

    localparam logic [OP_W-1:0] OPC_READ  = 8'hD0;
    localparam logic [OP_W-1:0] OPC_WRITE = 8'hE0;

    typedef struct packed {
        logic [OP_W-1:0]   opcode;
        logic [PORT_W-1:0] port;
        logic [OFS_W-1:0]  regofs;
        logic [BYTE_N-1:0] ben;
        logic [3:0]        spare;
    } cmd_word_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_AWAIT = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        OPK_NONE  = 2'd0,
        OPK_READ  = 2'd1,
        OPK_WRITE = 2'd2
    } op_kind_t;

    function automatic op_kind_t decode_op(input logic [OP_W-1:0] op);
        op_kind_t k;
        if (op == OPC_READ)       k = OPK_READ;
        else if (op == OPC_WRITE) k = OPK_WRITE;
        else                      k = OPK_NONE;
        return k;
    endfunction

endpackage

// File: rtl/mbb_byte_mask.sv
module mbb_byte_mask #(
    parameter int BYTE_N = 4,
    localparam int W = BYTE_N * 8
) (
    input  logic [W-1:0]      din,
    input  logic [BYTE_N-1:0] ben,
    output logic [W-1:0]      dout
);
    for (genvar b = 0; b < BYTE_N; b++) begin : g_lane
        assign dout[b*8 +: 8] = ben[b] ? din[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/mbb_sequencer.sv
module mbb_sequencer
    import mbb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic req_ready,
    input  logic rsp_valid,
    output logic busy,
    output logic req_valid,
    output logic rsp_take
);
    seq_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            SQ_IDLE:  if (launch)    st_d = SQ_ISSUE;
            SQ_ISSUE: if (req_ready) st_d = SQ_AWAIT;
            SQ_AWAIT: if (rsp_valid) st_d = SQ_IDLE;
            default:                 st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SQ_IDLE;
        else     st_q <= st_d;
    end

    assign busy      = (st_q != SQ_IDLE);
    assign req_valid = (st_q == SQ_ISSUE);
    assign rsp_take  = (st_q == SQ_AWAIT) && rsp_valid;
endmodule

// File: rtl/mbb_host_regs.sv
module mbb_host_regs
    import mbb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'hD0,
    parameter logic [ADDR_W-1:0] DATA_OFS = 'hD4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              accept,
    input  logic              rsp_load,
    input  logic [WORD_W-1:0] rsp_word,
    output cmd_word_t         cmd_q,
    output logic [WORD_W-1:0] data_q,
    output logic              cmd_hit,
    output logic [WORD_W-1:0] host_rdata
);
    logic data_hit;

    assign cmd_hit  = host_wr && accept && (host_addr == CTRL_OFS);
    assign data_hit = host_wr && accept && (host_addr == DATA_OFS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (cmd_hit) cmd_q <= cmd_word_t'(host_wdata);
            if (rsp_load)      data_q <= rsp_word;
            else if (data_hit) data_q <= host_wdata;
        end
    end

    always_comb begin
        if (host_addr == CTRL_OFS)      host_rdata = cmd_q;
        else if (host_addr == DATA_OFS) host_rdata = data_q;
        else                            host_rdata = '0;
    end
endmodule

// File: rtl/msgbus_bridge.sv
module msgbus_bridge
    import mbb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'hD0,
    parameter logic [ADDR_W-1:0] DATA_OFS = 'hD4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              busy,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [PORT_W-1:0] req_port,
    output logic [OFS_W-1:0]  req_offset,
    output logic              req_write,
    output logic [BYTE_N-1:0] req_be,
    output logic [WORD_W-1:0] req_data,
    input  logic              rsp_valid,
    input  logic [WORD_W-1:0] rsp_data
);
    cmd_word_t         cmd_q;
    cmd_word_t         cmd_in;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] rsp_masked;
    logic              cmd_hit;
    logic              launch;
    logic              rsp_take;
    logic              rsp_load;

    assign cmd_in   = cmd_word_t'(cfg_wdata);
    assign launch   = cmd_hit && (decode_op(cmd_in.opcode) != OPK_NONE);
    assign rsp_load = rsp_take && !req_write;

    mbb_host_regs #(
        .ADDR_W  (ADDR_W),
        .CTRL_OFS(CTRL_OFS),
        .DATA_OFS(DATA_OFS)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .host_wr   (cfg_wr),
        .host_addr (cfg_addr),
        .host_wdata(cfg_wdata),
        .accept    (!busy),
        .rsp_load  (rsp_load),
        .rsp_word  (rsp_masked),
        .cmd_q     (cmd_q),
        .data_q    (data_q),
        .cmd_hit   (cmd_hit),
        .host_rdata(cfg_rdata)
    );

    mbb_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .req_ready(req_ready),
        .rsp_valid(rsp_valid),
        .busy     (busy),
        .req_valid(req_valid),
        .rsp_take (rsp_take)
    );

    mbb_byte_mask #(.BYTE_N(BYTE_N)) u_wr_mask (
        .din (data_q),
        .ben (cmd_q.ben),
        .dout(req_data)
    );

    mbb_byte_mask #(.BYTE_N(BYTE_N)) u_rd_mask (
        .din (rsp_data),
        .ben (cmd_q.ben),
        .dout(rsp_masked)
    );

    assign req_port   = cmd_q.port;
    assign req_offset = cmd_q.regofs;
    assign req_be     = cmd_q.ben;
    assign req_write  = (decode_op(cmd_q.opcode) == OPK_WRITE);
endmodule

// File: rtl/mbb_bridge_checker.sv
module mbb_bridge_checker
    import mbb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'hD0
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [WORD_W-1:0] cfg_wdata,
    input logic              busy,
    input logic              req_valid,
    input logic              req_ready,
    input logic [PORT_W-1:0] req_port,
    input logic [OFS_W-1:0]  req_offset,
    input logic              req_write,
    input logic [BYTE_N-1:0] req_be,
    input logic [WORD_W-1:0] req_data,
    input logic              rsp_valid,
    input logic [WORD_W-1:0] data_q
);
    logic [WORD_W-1:0] be_bits;
    logic              good_cmd;

    always_comb begin
        for (int b = 0; b < BYTE_N; b++) be_bits[b*8 +: 8] = {8{req_be[b]}};
    end

    assign good_cmd = cfg_wr && !busy && (cfg_addr == CTRL_OFS) &&
                      ((cfg_wdata[31:24] == 8'hD0) || (cfg_wdata[31:24] == 8'hE0));

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_port) && $stable(req_offset)
            && $stable(req_write) && $stable(req_be) && $stable(req_data)); // R8

    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !req_valid); // R7

    AST_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        good_cmd |=> busy && req_valid); // R7

    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (rst)
        cfg_wr && !busy && (cfg_addr == CTRL_OFS) && !good_cmd |=> !busy); // R6

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        busy && !req_valid && rsp_valid |=> !busy); // R7

    AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy && req_valid |=> $stable(data_q)); // R9

    AST_WR_MASK: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write |-> (req_data & ~be_bits) == '0); // R4

    AST_RD_MASK: assert property (@(posedge clk) disable iff (rst)
        busy && !req_valid && rsp_valid && !req_write |=> (data_q & ~be_bits) == '0); // R5
endmodule

bind msgbus_bridge mbb_bridge_checker #(
    .ADDR_W  (ADDR_W),
    .CTRL_OFS(CTRL_OFS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .busy     (busy),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_port (req_port),
    .req_offset(req_offset),
    .req_write(req_write),
    .req_be   (req_be),
    .req_data (req_data),
    .rsp_valid(rsp_valid),
    .data_q   (data_q)
);

// File: tb/msgbus_bridge_bench.sv
module msgbus_bridge_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic        busy, req_valid, req_write;
    logic        req_ready = 1'b0;
    logic [7:0]  req_port, req_offset;
    logic [3:0]  req_be;
    logic [31:0] req_data;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = 32'h0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit stall = 0;

    always #5 clk = ~clk;

    msgbus_bridge u_msgbus_bridge (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
        .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port),
        .req_offset(req_offset), .req_write(req_write), .req_be(req_be),
        .req_data(req_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    function automatic logic [31:0] lanes(input logic [3:0] be);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[b*8 +: 8] = be[b] ? 8'hFF : 8'h00;
        return m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference: 0 idle, 1 issuing, 2 waiting
    int          m_state = 0;
    logic [31:0] m_cmd = 0;
    logic [31:0] m_data = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_cmd = 0; m_data = 0;
        end else begin
            case (m_state)
                0: if (cfg_wr) begin
                       if (cfg_addr == 8'hD0) begin
                           m_cmd = cfg_wdata;
                           if (cfg_wdata[31:24] == 8'hD0 || cfg_wdata[31:24] == 8'hE0) m_state = 1;
                       end else if (cfg_addr == 8'hD4) m_data = cfg_wdata;
                   end
                1: if (req_ready) m_state = 2;
                default: if (rsp_valid) begin
                       if (m_cmd[31:24] == 8'hD0) m_data = rsp_data & lanes(m_cmd[7:4]);
                       m_state = 0;
                   end
            endcase
        end
    end

    // target register store and responder
    logic [31:0] tmem [int unsigned];
    bit          p_rv = 0, p_rr = 0, p_wr = 0;
    logic [15:0] p_key = 0;
    logic [3:0]  p_be = 0;
    logic [31:0] p_data = 0;
    bit          pend = 0, pend_rd = 0;
    int          pend_cnt = 0;
    int unsigned pend_key = 0;

    function automatic logic [31:0] tread(input int unsigned k);
        if (tmem.exists(k)) return tmem[k];
        return 32'hC3A5_0000 ^ k;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            logic [31:0] exp_rd;
            exp_rd = (cfg_addr == 8'hD0) ? m_cmd : (cfg_addr == 8'hD4) ? m_data : 32'h0;
            check("R7 busy", {31'b0, busy}, {31'b0, m_state != 0});
            check("R8 req_valid", {31'b0, req_valid}, {31'b0, m_state == 1});
            check("R2 cfg_rdata", cfg_rdata, exp_rd);
            if (m_state == 1) begin
                check("R3 req_port", {24'b0, req_port}, {24'b0, m_cmd[23:16]});
                check("R3 req_offset", {24'b0, req_offset}, {24'b0, m_cmd[15:8]});
                check("R3 req_be", {28'b0, req_be}, {28'b0, m_cmd[7:4]});
                check("R4 req_write", {31'b0, req_write}, {31'b0, m_cmd[31:24] == 8'hE0});
                if (m_cmd[31:24] == 8'hE0)
                    check("R4 req_data", req_data, m_data & lanes(m_cmd[7:4]));
            end
        end
        // responder
        if (p_rv && p_rr) begin
            pend = 1; pend_rd = !p_wr; pend_key = {16'h0, p_key};
            pend_cnt = $urandom % 3;
            if (p_wr) tmem[pend_key] = (tread(pend_key) & ~lanes(p_be)) | (p_data & lanes(p_be));
        end
        rsp_valid = 0;
        rsp_data = $urandom;
        if (pend) begin
            if (pend_cnt == 0) begin
                rsp_valid = 1;
                if (pend_rd) rsp_data = tread(pend_key);
                pend = 0;
            end else pend_cnt--;
        end else if (($urandom % 8) == 0) begin
            rsp_valid = 1;
        end
        p_rv = req_valid; p_wr = req_write; p_key = {req_port, req_offset};
        p_be = req_be; p_data = req_data;
        req_ready = stall ? 1'b0 : (($urandom % 4) != 0);
        p_rr = req_ready;
    end

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #2;
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); #2;
        cfg_wr = 0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); #2;
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_idle;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); #3;
            if (!busy) break;
        end
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        #2 rst = 0;
        // R1 reset state
        @(negedge clk); #3;
        check("R1 busy after reset", {31'b0, busy}, 32'h0);
        check("R1 req_valid after reset", {31'b0, req_valid}, 32'h0);
        host_read(8'hD0, v); check("R1 cmd word after reset", v, 32'h0);
        host_read(8'hD4, v); check("R1 data word after reset", v, 32'h0);
        // R2 data word and unused offset
        host_write(8'hD4, 32'h1234_5678);
        host_read(8'hD4, v); check("R2 data word load", v, 32'h1234_5678);
        host_read(8'h40, v); check("R2 unused offset", v, 32'h0);
        // R4 full write, R10 data unchanged, R3 readback
        host_write(8'hD0, 32'hE003_10F0);
        wait_idle();
        host_read(8'hD4, v); check("R10 data after write op", v, 32'h1234_5678);
        host_read(8'hD0, v); check("R3 cmd readback", v, 32'hE003_10F0);
        // R5 full read
        host_write(8'hD0, 32'hD003_10F0);
        wait_idle();
        host_read(8'hD4, v); check("R5 full read", v, 32'h1234_5678);
        // R5 partial read, mask 0101
        host_write(8'hD0, 32'hD003_1050);
        wait_idle();
        host_read(8'hD4, v); check("R5 masked read", v, 32'h0034_0078);
        // R4 partial write, mask 0011
        host_write(8'hD4, 32'hAABB_CCDD);
        host_write(8'hD0, 32'hE003_1030);
        wait_idle();
        host_write(8'hD0, 32'hD003_10F0);
        wait_idle();
        host_read(8'hD4, v); check("R4 partial write merge", v, 32'h1234_CCDD);
        // R6 unknown opcode
        host_write(8'hD0, 32'h1205_20F7);
        #1 check("R6 no busy", {31'b0, busy}, 32'h0);
        check("R6 no request", {31'b0, req_valid}, 32'h0);
        host_read(8'hD0, v); check("R6 cmd captured", v, 32'h1205_20F7);
        // R7 / R9 busy window with stalled request
        stall = 1;
        host_write(8'hD0, 32'hD003_10F0);
        #1 check("R7 busy after launch", {31'b0, busy}, 32'h1);
        host_write(8'hD4, 32'hDEAD_BEEF);
        host_write(8'hD0, 32'hE007_0010);
        host_read(8'hD4, v); check("R7 data held while busy", v, 32'h1234_CCDD);
        host_read(8'hD0, v); check("R9 cmd write ignored", v, 32'hD003_10F0);
        stall = 0;
        wait_idle();
        host_read(8'hD4, v); check("R9 data write ignored", v, 32'h1234_CCDD);
        // random traffic, checked every cycle by the reference model
        for (int i = 0; i < 400; i++) begin
            int sel;
            logic [31:0] w;
            sel = $urandom % 6;
            w = $urandom;
            w[23:16] = 8'($urandom % 4);
            w[15:8]  = 8'($urandom % 8);
            if (sel < 2)       w[31:24] = 8'hD0;
            else if (sel < 4)  w[31:24] = 8'hE0;
            if (sel == 5) host_write(8'hD4, w);
            else host_write(((i % 9) == 0) ? 8'hD8 : 8'hD0, w);
            repeat ($urandom % 4) @(negedge clk);
            host_read((($urandom % 2) == 0) ? 8'hD0 : 8'hD4, v);
        end
        wait_idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R7 actual=%h expected=%h", 32'h1, 32'h0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule